// File: doc/BRIEF.md
# Masked Identifier Acceptance Filter

This block decides whether one received frame belongs to one configured message object. It compares the frame's identifier, its format (standard or extended) and its type (data or remote) against the object's stored identifier, format flag and direction flag. A per-object mask can leave out any identifier bit. The mask can also leave out the format flag and the direction flag. The object can switch the whole mask off, and in that case every field must match exactly.

Standard and extended identifiers share one 29-bit field. An 11-bit standard identifier sits in the upper eleven bits of that field. A received data frame is looked up against objects set to receive. A received remote frame is looked up against objects set to transmit. An object that is not enabled never matches.

The caller presents one frame and one object per cycle, with a valid strobe. The decision comes back as a registered flag one clock later, together with its own valid strobe. Scanning many objects, storing the frame and receiving bits from the bus are the caller's work.

Top module: `id_accept_filter`

## Requirements
- R1: While reset (`rst_n` low) is applied and after it is released, `out_valid` and `out_match` are 0 until a frame is presented.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R3: When `obj_enable` is 0, `out_match` is 0 whatever the other inputs are.
- R4: When `mask_en` is 0, a match needs all compared identifier bits, the format flag (`obj_ext` against `rx_ext`) and the direction flag to be equal. A single differing bit gives no match.
- R5: When `mask_en` is 1, an identifier bit whose `obj_mask` bit is 0 cannot prevent a match. An identifier bit whose `obj_mask` bit is 1 must be equal.
- R6: When `mask_en` is 1, `mask_ext` = 1 makes the format flag take part in the comparison, and `mask_ext` = 0 makes it irrelevant.
- R7: When `mask_en` is 1, `mask_dir` = 1 makes the direction flag take part in the comparison, and `mask_dir` = 0 makes it irrelevant.
- R8: The direction a frame requires is encoded as follows: a data frame (`rx_remote` = 0) requires `obj_dir` = 0 (receive), and a remote frame (`rx_remote` = 1) requires `obj_dir` = 1 (transmit).
- R9: For a standard frame (`rx_ext` = 0), bits 28 to 18 of the identifier field are compared and bits 17 to 0 are not. For an extended frame (`rx_ext` = 1), all 29 bits are compared.
- R10: `out_match` is 0 in every cycle in which `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A frame/object pair is presented this cycle |
| rx_id | input | 29 | Received identifier (standard identifier in bits 28:18) |
| rx_ext | input | 1 | Received frame uses the extended format |
| rx_remote | input | 1 | Received frame is a remote frame |
| obj_id | input | 29 | Object identifier |
| obj_ext | input | 1 | Object expects the extended format |
| obj_dir | input | 1 | Object direction: 0 receive, 1 transmit |
| obj_mask | input | 29 | Identifier mask: 1 = bit compared |
| mask_ext | input | 1 | Format flag compared when mask in use |
| mask_dir | input | 1 | Direction flag compared when mask in use |
| mask_en | input | 1 | Apply the mask fields |
| obj_enable | input | 1 | Object is configured and may match |
| out_valid | output | 1 | Decision valid this cycle |
| out_match | output | 1 | Frame accepted by the object |

## Verification
A table of frame/object pairs is used first. Exact matches are paired with near misses that differ in a single identifier bit, in the format flag or in the direction flag. This separates a filter that really compares each field from one that ignores it. Masked rows flip one masked-out bit, and then the same bit with the mask set, which shows that the mask acts bit by bit. The same method is applied to the format flag and the direction flag. Standard-frame rows carry different bits in the low eighteen positions, and one extended-frame row carries the same difference, so the bench can tell the two identifier widths apart. Directed tests cover reset, the one-cycle latency, idle cycles and a disabled object.

// File: rtl/idf_pkg.sv
package idf_pkg;

    localparam logic DIR_RECEIVE  = 1'b0;
    localparam logic DIR_TRANSMIT = 1'b1;

    typedef struct packed {
        logic vld;
        logic hit;
    } idf_state_t;

    // Direction an object must hold to answer a frame of the given type.
    function automatic logic wanted_dir(input logic remote);
        return remote ? DIR_TRANSMIT : DIR_RECEIVE;
    endfunction

endpackage

// File: rtl/idf_care_mask.sv
// Builds the per-bit "compare this bit" vector, laid out {dir, ext, id}.
module idf_care_mask #(
    parameter int ID_W  = 29,
    parameter int STD_W = 11
) (
    input  logic            mask_en,
    input  logic [ID_W-1:0] obj_mask,
    input  logic            mask_ext,
    input  logic            mask_dir,
    input  logic            rx_ext,
    output logic [ID_W+1:0] care
);
    localparam int LOW_W = ID_W - STD_W;

    for (genvar i = 0; i < ID_W; i++) begin : g_id
        if (i < LOW_W) begin : g_low
            // low part only exists in extended frames
            assign care[i] = rx_ext & (mask_en ? obj_mask[i] : 1'b1);
        end else begin : g_high
            assign care[i] = mask_en ? obj_mask[i] : 1'b1;
        end
    end

    assign care[ID_W]   = mask_en ? mask_ext : 1'b1;
    assign care[ID_W+1] = mask_en ? mask_dir : 1'b1;

endmodule

// File: rtl/idf_masked_eq.sv
// Equality of two vectors restricted to the bits flagged in care.
module idf_masked_eq #(
    parameter int W = 31
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] care,
    output logic         eq
);
    logic [W-1:0] bit_ok;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_ok[i] = ~care[i] | ~(a[i] ^ b[i]);
    end

    assign eq = &bit_ok;

endmodule

// File: rtl/id_accept_filter.sv
module id_accept_filter
    import idf_pkg::*;
#(
    parameter int ID_W  = 29,
    parameter int STD_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [ID_W-1:0] rx_id,
    input  logic            rx_ext,
    input  logic            rx_remote,
    input  logic [ID_W-1:0] obj_id,
    input  logic            obj_ext,
    input  logic            obj_dir,
    input  logic [ID_W-1:0] obj_mask,
    input  logic            mask_ext,
    input  logic            mask_dir,
    input  logic            mask_en,
    input  logic            obj_enable,
    output logic            out_valid,
    output logic            out_match
);
    localparam int CMP_W = ID_W + 2;

    logic [CMP_W-1:0] care_c;
    logic [CMP_W-1:0] obj_vec_c;
    logic [CMP_W-1:0] rx_vec_c;
    logic             fields_eq_c;

    idf_state_t st_d, st_q;

    idf_care_mask #(.ID_W(ID_W), .STD_W(STD_W)) u_care (
        .mask_en  (mask_en),
        .obj_mask (obj_mask),
        .mask_ext (mask_ext),
        .mask_dir (mask_dir),
        .rx_ext   (rx_ext),
        .care     (care_c)
    );

    assign obj_vec_c = {obj_dir, obj_ext, obj_id};
    assign rx_vec_c  = {wanted_dir(rx_remote), rx_ext, rx_id};

    idf_masked_eq #(.W(CMP_W)) u_eq (
        .a    (obj_vec_c),
        .b    (rx_vec_c),
        .care (care_c),
        .eq   (fields_eq_c)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.hit = in_valid & obj_enable & fields_eq_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_match = st_q.hit;

endmodule

// File: rtl/idf_checker.sv
module idf_checker #(
    parameter int ID_W = 29
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [ID_W-1:0] rx_id,
    input logic            rx_ext,
    input logic            rx_remote,
    input logic [ID_W-1:0] obj_id,
    input logic            obj_ext,
    input logic            obj_dir,
    input logic [ID_W-1:0] obj_mask,
    input logic            mask_ext,
    input logic            mask_dir,
    input logic            mask_en,
    input logic            obj_enable,
    input logic            out_valid,
    input logic            out_match
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);  // R2
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);  // R2
    AST_DISABLED_OBJ: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !obj_enable) |=> !out_match);  // R3
    AST_EXACT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && obj_enable && !mask_en && rx_ext && obj_ext &&
         (rx_remote == obj_dir) && (rx_id == obj_id)) |=> out_match);  // R4
    AST_EXT_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mask_en && (rx_ext != obj_ext)) |=> !out_match);  // R4
    AST_OPEN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && obj_enable && mask_en && (obj_mask == '0) &&
         !mask_ext && !mask_dir) |=> out_match);  // R5
    AST_MATCH_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_match);  // R10
endmodule

bind id_accept_filter idf_checker #(.ID_W(ID_W)) u_idf_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .rx_id      (rx_id),
    .rx_ext     (rx_ext),
    .rx_remote  (rx_remote),
    .obj_id     (obj_id),
    .obj_ext    (obj_ext),
    .obj_dir    (obj_dir),
    .obj_mask   (obj_mask),
    .mask_ext   (mask_ext),
    .mask_dir   (mask_dir),
    .mask_en    (mask_en),
    .obj_enable (obj_enable),
    .out_valid  (out_valid),
    .out_match  (out_match)
);

// File: tb/tb_id_accept_filter.sv
module tb_id_accept_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [28:0] rx_id = '0;
    logic        rx_ext = 1'b0;
    logic        rx_remote = 1'b0;
    logic [28:0] obj_id = '0;
    logic        obj_ext = 1'b0;
    logic        obj_dir = 1'b0;
    logic [28:0] obj_mask = '0;
    logic        mask_ext = 1'b0;
    logic        mask_dir = 1'b0;
    logic        mask_en = 1'b0;
    logic        obj_enable = 1'b0;
    logic        out_valid;
    logic        out_match;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    id_accept_filter dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .rx_id(rx_id), .rx_ext(rx_ext), .rx_remote(rx_remote),
        .obj_id(obj_id), .obj_ext(obj_ext), .obj_dir(obj_dir),
        .obj_mask(obj_mask), .mask_ext(mask_ext), .mask_dir(mask_dir),
        .mask_en(mask_en), .obj_enable(obj_enable),
        .out_valid(out_valid), .out_match(out_match)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [28:0] oid;
        logic        oext;
        logic        odir;
        logic [28:0] msk;
        logic        mext;
        logic        mdir;
        logic        men;
        logic        oen;
        logic [28:0] rid;
        logic        rext;
        logic        rrem;
        logic        exp;
    } vec_t;

    localparam logic [28:0] IDA  = 29'h0ABCDE12;
    localparam logic [28:0] STDS = 29'h048C0000; // 11-bit 0x123 in bits 28:18
    localparam int NV = 16;

    localparam vec_t VECS [NV] = '{
        '{8'd4, IDA, 1'b1, 1'b0, 29'h0, 1'b0, 1'b0, 1'b0, 1'b1, IDA,          1'b1, 1'b0, 1'b1}, // R4 exact
        '{8'd4, IDA, 1'b1, 1'b0, 29'h0, 1'b0, 1'b0, 1'b0, 1'b1, IDA ^ 29'h1,  1'b1, 1'b0, 1'b0}, // R4 one bit
        '{8'd4, IDA, 1'b1, 1'b0, 29'h0, 1'b0, 1'b0, 1'b0, 1'b1, IDA,          1'b0, 1'b0, 1'b0}, // R4 format
        '{8'd3, IDA, 1'b1, 1'b0, 29'h0, 1'b0, 1'b0, 1'b0, 1'b0, IDA,          1'b1, 1'b0, 1'b0}, // R3 disabled
        '{8'd5, IDA, 1'b1, 1'b0, 29'h1FFFFFFE, 1'b1, 1'b1, 1'b1, 1'b1, IDA ^ 29'h1, 1'b1, 1'b0, 1'b1}, // R5 bit off
        '{8'd5, IDA, 1'b1, 1'b0, 29'h1FFFFFFF, 1'b1, 1'b1, 1'b1, 1'b1, IDA ^ 29'h1, 1'b1, 1'b0, 1'b0}, // R5 bit on
        '{8'd5, IDA, 1'b1, 1'b0, 29'h0, 1'b1, 1'b1, 1'b1, 1'b1, 29'h00001555,  1'b1, 1'b0, 1'b1}, // R5 all off
        '{8'd6, IDA, 1'b1, 1'b0, 29'h1FFFFFFF, 1'b0, 1'b1, 1'b1, 1'b1, IDA,   1'b0, 1'b0, 1'b1}, // R6 ext ignored
        '{8'd6, IDA, 1'b1, 1'b0, 29'h1FFFFFFF, 1'b1, 1'b1, 1'b1, 1'b1, IDA,   1'b0, 1'b0, 1'b0}, // R6 ext compared
        '{8'd7, IDA, 1'b1, 1'b1, 29'h1FFFFFFF, 1'b1, 1'b0, 1'b1, 1'b1, IDA,   1'b1, 1'b0, 1'b1}, // R7 dir ignored
        '{8'd7, IDA, 1'b1, 1'b1, 29'h1FFFFFFF, 1'b1, 1'b1, 1'b1, 1'b1, IDA,   1'b1, 1'b0, 1'b0}, // R7 dir compared
        '{8'd8, IDA, 1'b1, 1'b1, 29'h0, 1'b0, 1'b0, 1'b0, 1'b1, IDA,          1'b1, 1'b1, 1'b1}, // R8 remote to tx
        '{8'd8, IDA, 1'b1, 1'b0, 29'h0, 1'b0, 1'b0, 1'b0, 1'b1, IDA,          1'b1, 1'b1, 1'b0}, // R8 remote to rx
        '{8'd9, STDS, 1'b0, 1'b0, 29'h0, 1'b0, 1'b0, 1'b0, 1'b1, STDS | 29'h3FFFF, 1'b0, 1'b0, 1'b1}, // R9 low ignored
        '{8'd9, STDS, 1'b0, 1'b0, 29'h0, 1'b0, 1'b0, 1'b0, 1'b1, STDS ^ 29'h40000, 1'b0, 1'b0, 1'b0}, // R9 high bit
        '{8'd9, STDS, 1'b1, 1'b0, 29'h0, 1'b0, 1'b0, 1'b0, 1'b1, STDS | 29'h1, 1'b1, 1'b0, 1'b0}      // R9 ext low
    };

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic load(input vec_t v, input logic vld);
        in_valid   = vld;
        obj_id     = v.oid;  obj_ext  = v.oext; obj_dir  = v.odir;
        obj_mask   = v.msk;  mask_ext = v.mext; mask_dir = v.mdir;
        mask_en    = v.men;  obj_enable = v.oen;
        rx_id      = v.rid;  rx_ext   = v.rext; rx_remote = v.rrem;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #1600000;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R1: outputs quiet during and after reset
        repeat (3) @(posedge clk);
        #1;
        check("R1", out_valid, 1'b0, "valid in reset");
        check("R1", out_match, 1'b0, "match in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", out_valid, 1'b0, "valid after reset");

        // table walk
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            load(VECS[k], 1'b1);
            @(posedge clk); #1;
            check($sformatf("R%0d row %0d", VECS[k].req, k), out_match, VECS[k].exp, "match");
            check("R2", out_valid, 1'b1, "valid after strobe");
        end

        // R2/R10: matching inputs without strobe leave outputs low
        @(negedge clk);
        load(VECS[0], 1'b0);
        @(posedge clk); #1;
        check("R2", out_valid, 1'b0, "valid idle");
        check("R10", out_match, 1'b0, "match idle");

        // R2: latency, output not yet up before the registering edge
        @(negedge clk);
        load(VECS[0], 1'b1);
        #1;
        check("R2", out_valid, 1'b0, "valid before edge");
        @(posedge clk); #1;
        check("R2", out_valid, 1'b1, "valid one cycle later");
        check("R4", out_match, 1'b1, "match one cycle later");
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk); #1;
        check("R10", out_match, 1'b0, "match drops with valid");

        // R3: disabled object with fully open mask
        @(negedge clk);
        load(VECS[6], 1'b1);
        obj_enable = 1'b0;
        @(posedge clk); #1;
        check("R3", out_match, 1'b0, "disabled open mask");

        // R1: reset mid-stream clears the registered decision
        @(negedge clk);
        load(VECS[0], 1'b1);
        @(posedge clk); #1;
        rst_n = 1'b0;
        #1;
        check("R1", out_valid, 1'b0, "valid on reset assert");
        check("R1", out_match, 1'b0, "match on reset assert");

        finish_run();
    end

endmodule